// File: doc/BRIEF.md
# Variable-Length PWM With Auto-Reload

This block is a single-channel pulse-width modulator driven by a free-running counter. The counter steps only while a count-enable input is high, and a 2-bit length field sets the period to 2^8, 2^9, 2^10 or 2^11 counts. Software can change this field at run time. The output is held low while the counter, masked to the selected length, is below the compare value. The output is high for the rest of the period.

Software can reprogram the duty cycle without glitches. Each compare value has a shadow reload register. An access-select bit in the configuration register decides whether the two compare byte addresses reach the live compare register or its reload register. In the 9- to 11-bit lengths, the reload value moves into the live compare register on the same edge where the counter wraps. A sticky overflow flag records each wrap. The flag drives an interrupt line when the interrupt enable is set.

Top module: `pwm_reload_top`

## Requirements
- R1: The length field is config bits [1:0]. Values 0, 1, 2 and 3 select 8, 9, 10 and 11 bits. The counter, masked to that length, wraps from all ones to zero, so the PWM period is 2^(8+field) enabled counts.
- R2: The overflow flag (config bit 5) becomes 1 on the clock edge after which the masked counter wraps.
- R3: The overflow flag keeps its value until a config write changes it. A config write with bit 5 at 0 clears the flag and a write with bit 5 at 1 sets it. If a clearing write and a wrap occur on the same edge, the flag ends up set.
- R4: The interrupt output is high exactly when the overflow flag is 1 and the interrupt enable (config bit 6) is 1.
- R5: The access-select bit is config bit 7. Address 1 holds the low 8 bits and address 2 holds bits [10:8] in data bits [2:0]; its upper bits read 0. With the select bit at 0, these addresses read and write the live compare value. With the select bit at 1, they read and write the reload value.
- R6: In the 9-, 10- and 11-bit lengths, the reload value is copied into the live compare register on the wrap edge. In the 8-bit length the reload value never reaches the compare register.
- R7: Address 0 is the config register. After reset it reads 0, and its bits [4:2] always read 0 whatever is written. Address 3 reads 0.
- R8: The PWM output is 0 while the masked count is below the compare value and 1 otherwise. A compare value of 0 gives a constant 1.
- R9: The counter holds its value in every cycle where the count-enable input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| countEn | input | 1 | Counter advance enable |
| busAddr | input | 2 | Register address |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | 8 | Register write data |
| busRdData | output | 8 | Register read data for busAddr |
| pwmOut | output | 1 | Modulated output |
| irqOut | output | 1 | Overflow interrupt |

## Verification
If the counter or the length mask is wrong, the PWM output edges shift away from the expected count within one period. The output is compared on every clock, so such an error shows within at most 2048 cycles. A missed or unwanted reload copy changes the duty cycle starting with the next period, and it also appears at once when the compare register is read back. A flag error appears on the interrupt line in the cycle after the wrap, and the race between a clearing write and a wrap is driven on the exact edge where it happens.

// File: rtl/pwm_reload_pkg.sv
package pwm_reload_pkg;

  typedef enum logic [1:0] {
    ADDR_CFG  = 2'd0,
    ADDR_LO   = 2'd1,
    ADDR_HI   = 2'd2,
    ADDR_NONE = 2'd3
  } regAddr_t;

  // write strobes from control to datapath
  typedef struct packed {
    logic cmpLo;
    logic cmpHi;
    logic rldLo;
    logic rldHi;
  } dpWrite_t;

endpackage

// File: rtl/pwm_reload_ctrl.sv
module pwm_reload_ctrl
  import pwm_reload_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              wrapPulse,
  output dpWrite_t          dpWr,
  output logic              accSel,
  output logic              irqEn,
  output logic              ovFlag,
  output logic [LEN_W-1:0]  lenSel,
  output logic [DATA_W-1:0] cfgRead
);
  localparam int SEL_BIT  = DATA_W - 1;
  localparam int IE_BIT   = DATA_W - 2;
  localparam int FLAG_BIT = DATA_W - 3;

  regAddr_t addr;
  logic cfgWr;

  assign addr  = regAddr_t'(busAddr);
  assign cfgWr = busWrEn && (addr == ADDR_CFG);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accSel <= 1'b0;
      irqEn  <= 1'b0;
      ovFlag <= 1'b0;
      lenSel <= '0;
    end else begin
      if (cfgWr) begin
        accSel <= busWrData[SEL_BIT];
        irqEn  <= busWrData[IE_BIT];
        lenSel <= busWrData[LEN_W-1:0];
      end
      if (wrapPulse)  ovFlag <= 1'b1;
      else if (cfgWr) ovFlag <= busWrData[FLAG_BIT];
    end
  end

  always_comb begin
    dpWr.cmpLo = busWrEn && (addr == ADDR_LO) && !accSel;
    dpWr.cmpHi = busWrEn && (addr == ADDR_HI) && !accSel;
    dpWr.rldLo = busWrEn && (addr == ADDR_LO) &&  accSel;
    dpWr.rldHi = busWrEn && (addr == ADDR_HI) &&  accSel;
  end

  always_comb begin
    cfgRead              = '0;
    cfgRead[SEL_BIT]     = accSel;
    cfgRead[IE_BIT]      = irqEn;
    cfgRead[FLAG_BIT]    = ovFlag;
    cfgRead[LEN_W-1:0]   = lenSel;
  end

endmodule

// File: rtl/pwm_reload_dp.sv
module pwm_reload_dp
  import pwm_reload_pkg::*;
#(
  parameter int MIN_BITS = 8,
  parameter int LEN_W    = 2,
  parameter int DATA_W   = 8,
  parameter int MAX_BITS = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              countEn,
  input  logic [LEN_W-1:0]  lenSel,
  input  dpWrite_t          dpWr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              accSel,
  output logic              wrapPulse,
  output logic              pwmOut,
  output logic [DATA_W-1:0] rdLo,
  output logic [DATA_W-1:0] rdHi
);
  localparam int HI_W = MAX_BITS - DATA_W;

  logic [MAX_BITS-1:0] cntQ, cmpQ, rldQ;
  logic [MAX_BITS-1:0] lenMask, maskedCnt, viewReg;

  always_comb begin
    for (int i = 0; i < MAX_BITS; i++) lenMask[i] = (i < MIN_BITS + int'(lenSel));
  end

  assign maskedCnt = cntQ & lenMask;
  assign wrapPulse = countEn && (maskedCnt == lenMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cntQ <= '0;
    else if (countEn) cntQ <= (cntQ + 1'b1) & lenMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rldQ <= '0;
    end else begin
      if (dpWr.rldLo) rldQ[DATA_W-1:0]        <= wrData;
      if (dpWr.rldHi) rldQ[MAX_BITS-1:DATA_W] <= wrData[HI_W-1:0];
    end
  end

  // reload copy on the wrap edge takes precedence over a direct write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpQ <= '0;
    end else if (wrapPulse && (lenSel != '0)) begin
      cmpQ <= rldQ;
    end else begin
      if (dpWr.cmpLo) cmpQ[DATA_W-1:0]        <= wrData;
      if (dpWr.cmpHi) cmpQ[MAX_BITS-1:DATA_W] <= wrData[HI_W-1:0];
    end
  end

  assign pwmOut  = !(maskedCnt < cmpQ);
  assign viewReg = accSel ? rldQ : cmpQ;
  assign rdLo    = viewReg[DATA_W-1:0];
  assign rdHi    = {{(DATA_W-HI_W){1'b0}}, viewReg[MAX_BITS-1:DATA_W]};

endmodule

// File: rtl/pwm_reload_top.sv
module pwm_reload_top
  import pwm_reload_pkg::*;
#(
  parameter int MIN_BITS = 8,
  parameter int LEN_W    = 2,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              countEn,
  input  logic [1:0]        busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              pwmOut,
  output logic              irqOut
);
  localparam int MAX_BITS = MIN_BITS + (1 << LEN_W) - 1;

  dpWrite_t dpWr;
  logic accSel, irqEn, ovFlag, wrapPulse;
  logic [LEN_W-1:0]  lenSel;
  logic [DATA_W-1:0] cfgRead, rdLo, rdHi;

  pwm_reload_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .wrapPulse(wrapPulse), .dpWr(dpWr),
    .accSel(accSel), .irqEn(irqEn), .ovFlag(ovFlag), .lenSel(lenSel),
    .cfgRead(cfgRead)
  );

  pwm_reload_dp #(.MIN_BITS(MIN_BITS), .LEN_W(LEN_W), .DATA_W(DATA_W),
                  .MAX_BITS(MAX_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .countEn(countEn), .lenSel(lenSel),
    .dpWr(dpWr), .wrData(busWrData), .accSel(accSel),
    .wrapPulse(wrapPulse), .pwmOut(pwmOut), .rdLo(rdLo), .rdHi(rdHi)
  );

  assign irqOut = ovFlag & irqEn;

  always_comb begin
    unique case (regAddr_t'(busAddr))
      ADDR_CFG: busRdData = cfgRead;
      ADDR_LO:  busRdData = rdLo;
      ADDR_HI:  busRdData = rdHi;
      default:  busRdData = '0;
    endcase
  end

endmodule

// File: rtl/pwm_reload_chk.sv
module pwm_reload_chk #(
  parameter int LEN_W    = 2,
  parameter int DATA_W   = 8,
  parameter int MAX_BITS = 11
) (
  input logic                clk,
  input logic                rstN,
  input logic                countEn,
  input logic                busWrEn,
  input logic [1:0]          busAddr,
  input logic [DATA_W-1:0]   busRdData,
  input logic                pwmOut,
  input logic                irqOut,
  input logic                irqEn,
  input logic                ovFlag,
  input logic                wrapPulse,
  input logic [LEN_W-1:0]    lenSel,
  input logic [MAX_BITS-1:0] cntQ,
  input logic [MAX_BITS-1:0] cmpQ,
  input logic [MAX_BITS-1:0] rldQ
);
  assert_wrap_sets_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |=> ovFlag);

  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ovFlag && !(busWrEn && busAddr == 2'd0)) |=> ovFlag);

  assert_irq_masked_R4: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !irqOut);

  assert_irq_needs_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ovFlag);

  assert_reload_copy_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrapPulse && lenSel != '0) |=> (cmpQ == $past(rldQ)));

  assert_no_copy_short_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrapPulse && lenSel == '0 && !busWrEn) |=> $stable(cmpQ));

  assert_unused_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd0) |-> (busRdData[4:2] == 3'b000));

  assert_zero_cmp_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmpQ == '0) |-> pwmOut);

  assert_cnt_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !countEn |=> $stable(cntQ));

endmodule

bind pwm_reload_top pwm_reload_chk #(.LEN_W(LEN_W), .DATA_W(DATA_W), .MAX_BITS(MAX_BITS)) chk_i (
  .clk(clk), .rstN(rstN), .countEn(countEn), .busWrEn(busWrEn),
  .busAddr(busAddr), .busRdData(busRdData), .pwmOut(pwmOut), .irqOut(irqOut),
  .irqEn(irqEn), .ovFlag(ovFlag), .wrapPulse(wrapPulse), .lenSel(lenSel),
  .cntQ(dp_i.cntQ), .cmpQ(dp_i.cmpQ), .rldQ(dp_i.rldQ)
);

// File: tb/pwm_reload_top_tb_top.sv
`timescale 1ns/1ps
module pwm_reload_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic countEn = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic busWrEn = 1'b0;
  logic [7:0] busWrData = 8'd0;
  logic [7:0] busRdData;
  logic pwmOut, irqOut;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;
  bit live = 1'b0;

  // reference state
  int mCnt = 0, mCmp = 0, mRld = 0, mLen = 0, mSel = 0, mIe = 0, mFlag = 0;

  always #10 clk = ~clk;

  pwm_reload_top dut_i (
    .clk(clk), .rstN(rstN), .countEn(countEn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .pwmOut(pwmOut), .irqOut(irqOut)
  );

  function automatic int maskOf(int len);
    return (1 << (8 + len)) - 1;
  endfunction

  function automatic int expRead(int a);
    int v;
    v = (mSel != 0) ? mRld : mCmp;
    case (a)
      0: return (mSel << 7) | (mIe << 6) | (mFlag << 5) | mLen;
      1: return v & 8'hFF;
      2: return (v >> 8) & 7;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int msk, oSel, oLen, oRld, d;
    bit wrap;
    if (!rstN) begin
      mCnt = 0; mCmp = 0; mRld = 0; mLen = 0; mSel = 0; mIe = 0; mFlag = 0;
    end else begin
      msk  = maskOf(mLen);
      wrap = countEn && ((mCnt & msk) == msk);
      oSel = mSel; oLen = mLen; oRld = mRld; d = int'(busWrData);
      if (busWrEn) begin
        case (busAddr)
          2'd0: begin
            mSel = (d >> 7) & 1; mIe = (d >> 6) & 1; mFlag = (d >> 5) & 1; mLen = d & 3;
          end
          2'd1: if (oSel != 0) mRld = (mRld & 'h700) | d; else mCmp = (mCmp & 'h700) | d;
          2'd2: if (oSel != 0) mRld = (mRld & 'hFF) | ((d & 7) << 8);
                else mCmp = (mCmp & 'hFF) | ((d & 7) << 8);
          default: ;
        endcase
      end
      if (wrap) mFlag = 1;
      if (wrap && oLen != 0) mCmp = oRld;
      if (countEn) mCnt = (mCnt + 1) & msk;
    end
  end

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // every-clock comparison of the outputs (R1, R6, R8, R9 via pwmOut; R4 via irqOut)
  always @(negedge clk) begin
    if (live) begin
      check("R1/R6/R8/R9 pwmOut", int'(pwmOut),
            ((mCnt & maskOf(mLen)) < mCmp) ? 0 : 1);
      check("R4 irqOut", int'(irqOut), mFlag & mIe);
    end
  end

  // tasks start and end at a falling edge
  task automatic regWrite(int a, int d);
    busAddr = 2'(a); busWrData = 8'(d); busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic regRead(int a, string req);
    busAddr = 2'(a);
    #1;
    check(req, int'(busRdData), expRead(a));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    live = 1'b1;
    idle(1);
    // R7: reset state
    regRead(0, "R7 config after reset");
    check("R7 config reset literal", int'(busRdData), 0);
    regRead(1, "R5 compare low after reset");
    regRead(3, "R7 spare address");
    // R7: bits 4:2 ignore writes
    regWrite(0, 'h1C);
    regRead(0, "R7 unused bits");
    check("R7 unused bits literal", int'(busRdData), 0);
    // R5: select steering
    regWrite(1, 'h40);
    regWrite(0, 'h80);
    regWrite(1, 'h22);
    regWrite(2, 'hFF);
    regRead(1, "R5 reload low via select");
    regRead(2, "R5 reload high upper zero");
    check("R5 reload high literal", int'(busRdData), 7);
    regWrite(0, 'h00);
    regRead(1, "R5 compare low via select");
    check("R5 compare low literal", int'(busRdData), 'h40);
    // R1/R2/R6: 8-bit mode, reload must not be copied
    regWrite(2, 0);
    countEn = 1'b1;
    idle(600);
    regRead(0, "R2 flag after 8-bit wraps");
    regRead(1, "R6 no copy in 8-bit mode");
    check("R6 no copy literal", int'(busRdData), 'h40);
    // R3: clear, sw set
    regWrite(0, 'h00);
    regRead(0, "R3 flag cleared");
    regWrite(0, 'h20);
    regRead(0, "R3 flag set by write");
    // R4: interrupt enable
    regWrite(0, 'h40);
    idle(300);
    regRead(0, "R4 enable and flag");
    // R6: 9-bit mode with reload 0x100
    regWrite(0, 'hC1);
    regWrite(1, 'h00);
    regWrite(2, 'h01);
    regWrite(0, 'h01);
    idle(1100);
    regRead(2, "R6 copy in 9-bit mode");
    check("R6 copy literal", int'(busRdData), 1);
    // R9: counting paused
    countEn = 1'b0;
    idle(60);
    regRead(0, "R9 paused config");
    countEn = 1'b1;
    // R1: 10-bit and 11-bit lengths with reload
    regWrite(0, 'h82);
    regWrite(1, 'h90);
    regWrite(2, 'h02);
    regWrite(0, 'h02);
    idle(2200);
    regRead(1, "R6 copy in 10-bit mode");
    regWrite(0, 'h83);
    regWrite(1, 'h55);
    regWrite(2, 'h05);
    regWrite(0, 'h03);
    idle(4300);
    regRead(2, "R1 11-bit compare high");
    // R3: clearing write on the wrap edge
    regWrite(0, 'h40);
    while ((mCnt & 'hFF) != 'hFF) @(negedge clk);
    regWrite(0, 'h40);
    regRead(0, "R3 wrap wins over clear");
    check("R3 flag literal", (int'(busRdData) >> 5) & 1, 1);
    // R8: compare 0 gives constant high
    regWrite(1, 'h00);
    regWrite(2, 'h00);
    idle(300);
    check("R8 zero compare high", int'(pwmOut), 1);
    // R9: gated counting with irregular enable
    for (int i = 0; i < 700; i++) begin
      countEn = (i % 3) != 0;
      if (i == 5) regWrite(1, 'h30); else @(negedge clk);
    end
    regRead(1, "R9 compare after gated run");
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule